// File: doc/BRIEF.md
# I/O Cycle Wait-State Generator

This block lets a slow service controller finish CPU I/O cycles on the CPU's behalf. It watches the CPU's active-low I/O request strobe. When that strobe goes from high to low, the block pulls the CPU's active-low WAIT line low, which stalls the CPU. At the same time it raises a pending flag that the service controller can poll.

The controller then does the transfer and pulses a clear input. The clear releases WAIT even if the request strobe is still low. The block arms again only after the strobe returns high and falls once more. It also records whether the captured cycle was a read or a write.

A parameter decides which ports trigger the block:
- **Decoded mode:** only a window of port addresses triggers it.
- **Undecoded mode:** every I/O cycle triggers it.

All bus inputs are synchronised to the single system clock before use.

Top module: `io_wait_gen`

## Requirements
- R1: A cycle is recognised only on a high-to-low transition of `iorq_n`. A request held steadily low never sets the stall again.
- R2: Once a cycle is recognised, `wait_n` goes low and stays low until a clear is seen.
- R3: A clear releases `wait_n` (drives it high) even while `iorq_n` is still low. No further stall occurs until `iorq_n` goes high and then falls again.
- R4: A falling edge of `iorq_n` that arrives while `clr` is high is discarded. This includes an edge in the same synchronised clock as the clear.
- R5: With `DECODE=1`, only addresses whose bits 7 to 4 are all ones trigger a stall, which is ports 0xF0 to 0xFF. For example, 0x7F is ignored while 0xF0 and 0xFF trigger.
- R6: With `DECODE=0`, any I/O cycle triggers a stall, including at address 0x7F.
- R7: `pending` is always the inverse of `wait_n`: it is 1 exactly while the CPU is stalled.
- R8: `cyc_is_read` captures the value of `rd_n` at the trigger edge. It is 1 when `rd_n` was low (a read) and 0 when it was high (a write). It holds that value until the next accepted trigger.
- R9: A synchronous active-high `rst` forces `wait_n`=1, `pending`=0 and `cyc_is_read`=0 at the next rising clock edge.
- R10: An input change applied between clock edges reaches the outputs at the third following rising edge: two synchroniser stages plus the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| iorq_n | input | 1 | CPU I/O request strobe, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| addr | input | ADDR_W | CPU port address |
| clr | input | 1 | Release pulse from the service controller, active high |
| wait_n | output | 1 | Stall line to the CPU, active low |
| pending | output | 1 | A cycle is waiting for service |
| cyc_is_read | output | 1 | The captured cycle was a read |

## Verification
A stall latch stuck at 1 shows as `wait_n` held low after a clear. A stall latch stuck at 0 shows as `pending` never rising. Either fault is visible three clocks after the stimulus that should have changed the state. A detector that triggers on the level rather than the edge re-stalls the CPU within three clocks of a clear applied while the request is still low. A wrong address window or a wrong clear priority shows as a stall where the bench expects none, again at the third edge. A miscaptured direction shows on `cyc_is_read` together with the stall.

// File: rtl/io_wait_pkg.sv
package io_wait_pkg;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   // True when the top win_w bits of a are all ones.
   function automatic logic win_hit(input logic [15:0] a, input int unsigned aw,
                                    input int unsigned win_w);
      logic hit;
      hit = 1'b1;
      for (int unsigned b = 0; b < 16; b++) begin
         if (b < aw && b >= aw - win_w) hit = hit & a[b];
      end
      return hit;
   endfunction
endpackage

// File: rtl/io_sync.sv
module io_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_V = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("io_sync needs at least two stages");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= {STAGES{RST_V}};
      end else begin
         chain[0] <= d;
         for (int unsigned s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/io_edge_qual.sv
module io_edge_qual #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned WIN_W  = 4,
   parameter bit          DECODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_s,
   input  logic [ADDR_W-1:0] addr_s,
   output logic              req_prev,
   output logic              fall
);
   import io_wait_pkg::*;

   logic qual;

   always_ff @(posedge clk) begin
      if (rst) req_prev <= 1'b1;
      else     req_prev <= req_s;
   end

   if (DECODE) begin : g_decoded
      if (WIN_W == 0 || WIN_W > ADDR_W || ADDR_W > 16) begin : g_bad
         $error("io_edge_qual: WIN_W must be within 1..ADDR_W and ADDR_W <= 16");
      end
      logic [15:0] a_ext;
      assign a_ext = 16'(addr_s);
      assign qual  = win_hit(a_ext, ADDR_W, WIN_W);
   end else begin : g_open
      assign qual = 1'b1;
   end

   assign fall = req_prev & ~req_s & qual;
endmodule

// File: rtl/io_stall_latch.sv
module io_stall_latch (
   input  logic clk,
   input  logic rst,
   input  logic fall,
   input  logic clr_s,
   input  logic rd_s,
   output logic stall,
   output logic is_read
);
   always_ff @(posedge clk) begin
      if (rst) begin
         stall   <= 1'b0;
         is_read <= 1'b0;
      end else if (clr_s) begin
         stall <= 1'b0;
      end else if (fall) begin
         stall   <= 1'b1;
         is_read <= ~rd_s;
      end
   end

   assert_clear_wins_R4: assert property (@(posedge clk) disable iff (rst)
      clr_s |=> !stall);
   assert_set_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
      (fall && !clr_s) |=> stall);
   assert_hold_until_clear_R2: assert property (@(posedge clk) disable iff (rst)
      (stall && !clr_s) |=> stall);
   assert_dir_stable_R8: assert property (@(posedge clk) disable iff (rst)
      !(fall && !clr_s) |=> $stable(is_read));
endmodule

// File: rtl/io_wait_gen.sv
module io_wait_gen #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned WIN_W       = 4,
   parameter bit          DECODE      = 1'b1,
   parameter int unsigned SYNC_STAGES = io_wait_pkg::DEF_SYNC_STAGES
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              iorq_n,
   input  logic              rd_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              clr,
   output logic              wait_n,
   output logic              pending,
   output logic              cyc_is_read
);
   localparam int unsigned BUS_W = ADDR_W + 3;
   localparam logic [BUS_W-1:0] BUS_IDLE = {1'b1, 1'b1, 1'b0, {ADDR_W{1'b0}}};

   logic [BUS_W-1:0] bus_s;
   logic              req_s, rd_s, clr_s, req_prev, fall, stall;
   logic [ADDR_W-1:0] addr_s;

   io_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_V(BUS_IDLE)) u_sync (
      .clk(clk), .rst(rst), .d({iorq_n, rd_n, clr, addr}), .q(bus_s));

   assign {req_s, rd_s, clr_s, addr_s} = bus_s;

   io_edge_qual #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .DECODE(DECODE)) u_edge (
      .clk(clk), .rst(rst), .req_s(req_s), .addr_s(addr_s),
      .req_prev(req_prev), .fall(fall));

   io_stall_latch u_latch (
      .clk(clk), .rst(rst), .fall(fall), .clr_s(clr_s), .rd_s(rd_s),
      .stall(stall), .is_read(cyc_is_read));

   assign wait_n  = ~stall;
   assign pending = stall;

   assert_no_level_trigger_R1: assert property (@(posedge clk) disable iff (rst)
      (!req_s && !req_prev) |=> !$rose(pending));
   assert_rise_needs_edge_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(pending) |-> ($past(req_prev) && !$past(req_s)));

   if (DECODE) begin : g_win_chk
      assert_window_R5: assert property (@(posedge clk) disable iff (rst)
         $rose(pending) |-> (&$past(addr_s[ADDR_W-1 -: WIN_W])));
   end
endmodule

// File: tb/sim_io_wait_gen.sv
module sim_io_wait_gen;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       iorq_n = 1'b1, rd_n = 1'b1, clr = 1'b0;
   logic [7:0] addr = 8'h00;
   logic       w0, p0, r0, w1, p1, r1;
   int         n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   io_wait_gen #(.DECODE(1'b1)) u0 (.clk(clk), .rst(rst), .iorq_n(iorq_n), .rd_n(rd_n),
      .addr(addr), .clr(clr), .wait_n(w0), .pending(p0), .cyc_is_read(r0));
   io_wait_gen #(.DECODE(1'b0)) u1 (.clk(clk), .rst(rst), .iorq_n(iorq_n), .rd_n(rd_n),
      .addr(addr), .clr(clr), .wait_n(w1), .pending(p1), .cyc_is_read(r1));

   // {iorq_n, rd_n, addr, clr, exp_wait_n, exp_pending, exp_read}
   localparam int NV = 14;
   localparam logic [13:0] VEC [NV] = '{
      {1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0},  // idle
      {1'b0, 1'b0, 8'hF3, 1'b0, 1'b0, 1'b1, 1'b1},  // read trigger R2 R8
      {1'b0, 1'b0, 8'hF3, 1'b1, 1'b1, 1'b0, 1'b1},  // clear while low R3
      {1'b0, 1'b0, 8'hF3, 1'b0, 1'b1, 1'b0, 1'b1},  // level, no retrigger R1
      {1'b1, 1'b1, 8'hF3, 1'b0, 1'b1, 1'b0, 1'b1},
      {1'b0, 1'b1, 8'hF0, 1'b0, 1'b0, 1'b1, 1'b0},  // write at F0 R5 R8
      {1'b0, 1'b1, 8'hF0, 1'b1, 1'b1, 1'b0, 1'b0},
      {1'b1, 1'b1, 8'hF0, 1'b1, 1'b1, 1'b0, 1'b0},
      {1'b0, 1'b0, 8'hF0, 1'b1, 1'b1, 1'b0, 1'b0},  // edge during clear R4
      {1'b0, 1'b0, 8'hF0, 1'b0, 1'b1, 1'b0, 1'b0},
      {1'b1, 1'b0, 8'h7F, 1'b0, 1'b1, 1'b0, 1'b0},
      {1'b0, 1'b0, 8'h7F, 1'b0, 1'b1, 1'b0, 1'b0},  // outside window R5
      {1'b1, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0},
      {1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1}   // top of window R5
   };

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive(input logic q, input logic r, input logic [7:0] a, input logic c);
      @(negedge clk);
      iorq_n = q; rd_n = r; addr = a; clr = c;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      #5;
   endtask

   initial begin
      #(200000 * 20);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      check("R9 reset wait_n", w0, 1'b1);
      check("R9 reset pending", p0, 1'b0);
      check("R9 reset read", r0, 1'b0);
      @(negedge clk); rst = 1'b0;
      settle();

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][13], VEC[i][12], VEC[i][11:4], VEC[i][3]);
         settle();
         check($sformatf("R1-table vec %0d wait_n R2 R3 R4 R5", i), w0, VEC[i][2]);
         check($sformatf("vec %0d pending R7", i), p0, VEC[i][1]);
         check($sformatf("vec %0d read R8", i), r0, VEC[i][0]);
         if (i == 11) begin
            check("R6 undecoded stalls at 7F", w1, 1'b0);
            check("R6 undecoded pending", p1, 1'b1);
         end
      end

      // release and rearm
      drive(1'b1, 1'b1, 8'hF5, 1'b1); settle();
      drive(1'b1, 1'b1, 8'hF5, 1'b0); settle();
      check("R3 released", w0, 1'b1);

      // R10 latency
      drive(1'b0, 1'b1, 8'hF5, 1'b0);
      repeat (2) @(posedge clk); #5;
      check("R10 no change after two edges", w0, 1'b1);
      @(posedge clk); #5;
      check("R10 stall at third edge", w0, 1'b0);
      check("R10 pending at third edge", p0, 1'b1);

      // R4 clear and edge in the same clock
      drive(1'b1, 1'b1, 8'hF5, 1'b1); settle();
      drive(1'b0, 1'b0, 8'hF5, 1'b1); settle();
      check("R4 same-clock clear wins", w0, 1'b1);
      drive(1'b0, 1'b0, 8'hF5, 1'b0); settle();
      check("R4 edge not remembered", w0, 1'b1);

      // R9 reset while stalled
      drive(1'b1, 1'b1, 8'hF5, 1'b0); settle();
      drive(1'b0, 1'b0, 8'hF5, 1'b0); settle();
      check("R2 stalled before reset", w0, 1'b0);
      @(negedge clk); rst = 1'b1; iorq_n = 1'b1;
      @(posedge clk); #5;
      check("R9 reset releases wait_n", w0, 1'b1);
      check("R9 reset clears pending", p0, 1'b0);
      check("R9 reset clears read", r0, 1'b0);
      @(negedge clk); rst = 1'b0;
      settle();
      check("R9 stays idle after reset", w0, 1'b1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule